// File: doc/BRIEF.md
# DMA Completion Status Resolver

The resolver sits behind a DMA channel's completion path. Each completion record carries an 8-bit command opcode, a 4-bit hardware status and a tag. The resolver classifies the record into one of three outcomes. A record can complete cleanly, or complete with a 3-bit outcome code. A failed read can instead be turned into a reconstructing read and pushed back to the head of the pending-command queue, so that it issues ahead of newer work. The queue itself is outside the block. Only its push port is driven from here. A global scrub-enable level decides whether a failed read may be retried.

Records enter on a valid/ready port. The decision is registered in a one-entry holding stage. From that stage a record leaves by one of two valid/ready ports: the result port or the retry port, never both. A held record stays unchanged until its port takes it. While it waits, `in_ready` stays low. When the held record drains in a cycle, a new record may be accepted in that same cycle, so the block sustains one record per clock.

Saturating counters track the status bits seen and the failures and retries for each command type. Each counter is updated in the cycle its record is accepted.

Top module: `dma_cmpl_resolver`

## Requirements
- R1: A read (opcode 0xC0) whose status has CRC (bit 0) or hard error (bit 1) set, accepted while `scrub_en` is 1, leaves on the retry port with opcode 0xE0 and its tag. It produces no result, and `cnt_rd_retry` increments.
- R2: The same read accepted while `scrub_en` is 0 leaves on the result port with code 0x2 (hardware fault), and `cnt_rd_fail` increments.
- R3: A read with only fault (bit 3) set gives code 0x2 and increments `cnt_rd_fail`. A read with only soft error (bit 2) set gives code 0x0 and increments no failure counter.
- R4: A reconstructing read (0xE0) with CRC or hard error gives code 0x2 and increments `cnt_rd_fail`, even with `scrub_en` 1. With only soft or fault bits it gives code 0x0.
- R5: A write (0x80) with nonzero status gives code 0x2 and increments `cnt_wr_fail`. A discard (0x70) with nonzero status gives code 0x2 and increments `cnt_dc_fail`.
- R6: Any other opcode with nonzero status gives code 0x1 (software error) and increments no per-command failure counter.
- R7: A status of zero gives code 0x0 for every opcode and changes no counter.
- R8: `cnt_crc`, `cnt_hard` and `cnt_soft` each increment whenever status bit 0, 1 or 2 respectively is set in an accepted record, whatever the outcome and opcode.
- R9: Every counter stops at its all-ones value and never wraps.
- R10: A record held on the result or retry port keeps its valid, code, opcode and tag stable until that port's ready is high. Meanwhile `in_ready` is low, and no record is lost or duplicated.
- R11: In a cycle where the held record drains, or nothing is held, `in_ready` is high and a new record is accepted.
- R12: After reset, both output valids are low, `in_ready` is high and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scrub_en | input | 1 | Allows failed reads to be retried as reconstructing reads |
| in_valid | input | 1 | Completion record present |
| in_ready | output | 1 | Record accepted when high together with in_valid |
| in_op | input | 8 | Command opcode of the completed record |
| in_status | input | 4 | Hardware status bits (0 CRC, 1 hard, 2 soft, 3 fault) |
| in_tag | input | TAG_W | Record tag, carried through |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumer accepts |
| res_code | output | 3 | Outcome code (0x1 software error, 0x2 hardware fault) |
| res_op | output | 8 | Opcode of the finished record |
| res_tag | output | TAG_W | Tag of the finished record |
| rq_valid | output | 1 | Retry push request to the pending queue |
| rq_ready | input | 1 | Pending queue accepts the push |
| rq_op | output | 8 | Rewritten opcode for the retry |
| rq_tag | output | TAG_W | Tag of the retried record |
| cnt_crc | output | CNT_W | CRC error count |
| cnt_hard | output | CNT_W | Hard error count |
| cnt_soft | output | CNT_W | Soft error count |
| cnt_rd_retry | output | CNT_W | Reads turned into retries |
| cnt_rd_fail | output | CNT_W | Reads and reconstructing reads that failed |
| cnt_wr_fail | output | CNT_W | Writes that failed |
| cnt_dc_fail | output | CNT_W | Discards that failed |

## Verification
Two functions can fall in the same clock edge: draining the held record and accepting the next one. The bench provokes this by stalling the retry port with a retry already held and a new write record waiting. It confirms that `in_ready` stays low and the retry stays stable. It then raises `rq_ready` and checks that, on that single edge, the retry leaves and the write is taken and presented on the result port. Counter saturation is exercised separately by pushing far more failing writes than the counter range.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam logic [7:0] OP_DISCARD = 8'h70;
  localparam logic [7:0] OP_WRITE   = 8'h80;
  localparam logic [7:0] OP_READ    = 8'hC0;
  localparam logic [7:0] OP_RECON   = 8'hE0;

  localparam int SB_CRC   = 0;
  localparam int SB_HARD  = 1;
  localparam int SB_SOFT  = 2;
  localparam int SB_FAULT = 3;

  localparam logic [2:0] RC_OK      = 3'h0;
  localparam logic [2:0] RC_SWERR   = 3'h1;
  localparam logic [2:0] RC_HWFAULT = 3'h2;
  localparam logic [2:0] RC_CANCEL  = 3'h4;

  localparam int EV_CRC      = 0;
  localparam int EV_HARD     = 1;
  localparam int EV_SOFT     = 2;
  localparam int EV_RD_RETRY = 3;
  localparam int EV_RD_FAIL  = 4;
  localparam int EV_WR_FAIL  = 5;
  localparam int EV_DC_FAIL  = 6;
  localparam int NUM_EV      = 7;

  typedef struct packed {
    logic       retry;
    logic [2:0] code;
    logic [7:0] op;
  } verdict_t;
endpackage

// File: rtl/dcr_decide.sv
module dcr_decide
  import dcr_pkg::*;
(
  input  logic [7:0]        op,
  input  logic [3:0]        status,
  input  logic              scrub_en,
  output verdict_t          verdict,
  output logic [NUM_EV-1:0] events
);
  logic media_err;
  assign media_err = status[SB_CRC] | status[SB_HARD];

  always_comb begin
    verdict.retry = 1'b0;
    verdict.code  = RC_OK;
    verdict.op    = op;
    events        = '0;
    events[EV_CRC]  = status[SB_CRC];
    events[EV_HARD] = status[SB_HARD];
    events[EV_SOFT] = status[SB_SOFT];
    if (status != 4'd0) begin
      case (op)
        OP_READ: begin
          if (media_err && scrub_en) begin
            verdict.retry       = 1'b1;
            verdict.op          = OP_RECON;
            events[EV_RD_RETRY] = 1'b1;
          end else if (media_err || status[SB_FAULT]) begin
            verdict.code       = RC_HWFAULT;
            events[EV_RD_FAIL] = 1'b1;
          end
        end
        OP_RECON: begin
          if (media_err) begin
            verdict.code       = RC_HWFAULT;
            events[EV_RD_FAIL] = 1'b1;
          end
        end
        OP_WRITE: begin
          verdict.code       = RC_HWFAULT;
          events[EV_WR_FAIL] = 1'b1;
        end
        OP_DISCARD: begin
          verdict.code       = RC_HWFAULT;
          events[EV_DC_FAIL] = 1'b1;
        end
        default: verdict.code = RC_SWERR;
      endcase
    end
  end
endmodule

// File: rtl/dcr_counters.sv
module dcr_counters #(
  parameter int NUM = 7,
  parameter int W   = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [NUM-1:0] inc,
  output logic [NUM*W-1:0] cnt_flat
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  for (genvar i = 0; i < NUM; i++) begin : g_cnt
    logic [W-1:0] c;
    always_ff @(posedge clk) begin
      if (rst)
        c <= '0;
      else if (en && inc[i] && c != TOP)
        c <= c + 1'b1;
    end
    assign cnt_flat[i*W +: W] = c;
  end
endmodule

// File: rtl/dcr_hold.sv
module dcr_hold #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             load_retry,
  input  logic [2:0]       load_code,
  input  logic [7:0]       load_op,
  input  logic [TAG_W-1:0] load_tag,
  input  logic             res_ready,
  input  logic             rq_ready,
  output logic             free,
  output logic             res_valid,
  output logic             rq_valid,
  output logic [2:0]       code,
  output logic [7:0]       op,
  output logic [TAG_W-1:0] tag
);
  logic held;
  logic is_retry;

  assign free      = !held || (is_retry ? rq_ready : res_ready);
  assign res_valid = held && !is_retry;
  assign rq_valid  = held && is_retry;

  always_ff @(posedge clk) begin
    if (rst) begin
      held     <= 1'b0;
      is_retry <= 1'b0;
      code     <= '0;
      op       <= '0;
      tag      <= '0;
    end else if (free) begin
      held <= load;
      if (load) begin
        is_retry <= load_retry;
        code     <= load_code;
        op       <= load_op;
        tag      <= load_tag;
      end
    end
  end
endmodule

// File: rtl/dma_cmpl_resolver.sv
module dma_cmpl_resolver
  import dcr_pkg::*;
#(
  parameter int TAG_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scrub_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_op,
  input  logic [3:0]       in_status,
  input  logic [TAG_W-1:0] in_tag,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [2:0]       res_code,
  output logic [7:0]       res_op,
  output logic [TAG_W-1:0] res_tag,
  output logic             rq_valid,
  input  logic             rq_ready,
  output logic [7:0]       rq_op,
  output logic [TAG_W-1:0] rq_tag,
  output logic [CNT_W-1:0] cnt_crc,
  output logic [CNT_W-1:0] cnt_hard,
  output logic [CNT_W-1:0] cnt_soft,
  output logic [CNT_W-1:0] cnt_rd_retry,
  output logic [CNT_W-1:0] cnt_rd_fail,
  output logic [CNT_W-1:0] cnt_wr_fail,
  output logic [CNT_W-1:0] cnt_dc_fail
);
  verdict_t           verdict;
  logic [NUM_EV-1:0]  events;
  logic               accept;
  logic [NUM_EV*CNT_W-1:0] cnt_flat;
  logic [2:0]         h_code;
  logic [7:0]         h_op;
  logic [TAG_W-1:0]   h_tag;

  assign accept = in_valid && in_ready;

  dcr_decide u_decide (
    .op       (in_op),
    .status   (in_status),
    .scrub_en (scrub_en),
    .verdict  (verdict),
    .events   (events)
  );

  dcr_hold #(.TAG_W(TAG_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .load_retry (verdict.retry),
    .load_code  (verdict.code),
    .load_op    (verdict.op),
    .load_tag   (in_tag),
    .res_ready  (res_ready),
    .rq_ready   (rq_ready),
    .free       (in_ready),
    .res_valid  (res_valid),
    .rq_valid   (rq_valid),
    .code       (h_code),
    .op         (h_op),
    .tag        (h_tag)
  );

  dcr_counters #(.NUM(NUM_EV), .W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .en       (accept),
    .inc      (events),
    .cnt_flat (cnt_flat)
  );

  assign res_code = h_code;
  assign res_op   = h_op;
  assign res_tag  = h_tag;
  assign rq_op    = h_op;
  assign rq_tag   = h_tag;

  assign cnt_crc      = cnt_flat[EV_CRC*CNT_W      +: CNT_W];
  assign cnt_hard     = cnt_flat[EV_HARD*CNT_W     +: CNT_W];
  assign cnt_soft     = cnt_flat[EV_SOFT*CNT_W     +: CNT_W];
  assign cnt_rd_retry = cnt_flat[EV_RD_RETRY*CNT_W +: CNT_W];
  assign cnt_rd_fail  = cnt_flat[EV_RD_FAIL*CNT_W  +: CNT_W];
  assign cnt_wr_fail  = cnt_flat[EV_WR_FAIL*CNT_W  +: CNT_W];
  assign cnt_dc_fail  = cnt_flat[EV_DC_FAIL*CNT_W  +: CNT_W];
endmodule

// File: rtl/dcr_chk.sv
module dcr_chk #(
  parameter int TAG_W = 4,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [3:0]       in_status,
  input logic             res_valid,
  input logic             res_ready,
  input logic [2:0]       res_code,
  input logic [TAG_W-1:0] res_tag,
  input logic             rq_valid,
  input logic             rq_ready,
  input logic [7:0]       rq_op,
  input logic [TAG_W-1:0] rq_tag,
  input logic [CNT_W-1:0] cnt_crc,
  input logic [CNT_W-1:0] cnt_soft,
  input logic [CNT_W-1:0] cnt_wr_fail
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  a_r10_res_hold: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid && $stable(res_code) && $stable(res_tag));

  a_r10_rq_hold: assert property (@(posedge clk) disable iff (rst)
    rq_valid && !rq_ready |=> rq_valid && $stable(rq_op) && $stable(rq_tag));

  a_r10_blocked: assert property (@(posedge clk) disable iff (rst)
    (rq_valid && !rq_ready) || (res_valid && !res_ready) |-> !in_ready);

  a_r1_rq_recon: assert property (@(posedge clk) disable iff (rst)
    rq_valid |-> rq_op == 8'hE0);

  a_r11_idle_ready: assert property (@(posedge clk) disable iff (rst)
    !res_valid && !rq_valid |-> in_ready);

  a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_status == 4'd0 |=>
      $stable(cnt_crc) && $stable(cnt_soft) && $stable(cnt_wr_fail));

  a_r9_sat: assert property (@(posedge clk) disable iff (rst)
    cnt_crc == TOP |=> cnt_crc == TOP);

  a_r9_no_wrap: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_fail == TOP |=> cnt_wr_fail == TOP);
endmodule

bind dma_cmpl_resolver dcr_chk #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_status   (in_status),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_code    (res_code),
  .res_tag     (res_tag),
  .rq_valid    (rq_valid),
  .rq_ready    (rq_ready),
  .rq_op       (rq_op),
  .rq_tag      (rq_tag),
  .cnt_crc     (cnt_crc),
  .cnt_soft    (cnt_soft),
  .cnt_wr_fail (cnt_wr_fail)
);

// File: tb/dma_cmpl_resolver_tb.sv
module dma_cmpl_resolver_tb;
  localparam int TAG_W = 4;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scrub_en = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_op = '0;
  logic [3:0] in_status = '0;
  logic [TAG_W-1:0] in_tag = '0;
  logic res_valid, rq_valid;
  logic res_ready = 1'b1;
  logic rq_ready = 1'b1;
  logic [2:0] res_code;
  logic [7:0] res_op, rq_op;
  logic [TAG_W-1:0] res_tag, rq_tag;
  logic [CNT_W-1:0] cnt_crc, cnt_hard, cnt_soft, cnt_rd_retry, cnt_rd_fail, cnt_wr_fail, cnt_dc_fail;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  dma_cmpl_resolver #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .scrub_en(scrub_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_status(in_status), .in_tag(in_tag),
    .res_valid(res_valid), .res_ready(res_ready), .res_code(res_code),
    .res_op(res_op), .res_tag(res_tag),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_op(rq_op), .rq_tag(rq_tag),
    .cnt_crc(cnt_crc), .cnt_hard(cnt_hard), .cnt_soft(cnt_soft),
    .cnt_rd_retry(cnt_rd_retry), .cnt_rd_fail(cnt_rd_fail),
    .cnt_wr_fail(cnt_wr_fail), .cnt_dc_fail(cnt_dc_fail)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Present one record, wait for acceptance; returns at the negedge after the accepting edge.
  task automatic send(logic [7:0] op, logic [3:0] st, logic [TAG_W-1:0] tag);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_status = st; in_tag = tag;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R12", "in_ready", in_ready, 1);
    chk("R12", "res_valid", res_valid, 0);
    chk("R12", "rq_valid", rq_valid, 0);
    chk("R12", "counter sum", cnt_crc + cnt_hard + cnt_soft + cnt_rd_retry
        + cnt_rd_fail + cnt_wr_fail + cnt_dc_fail, 0);
  endtask

  task automatic t_read_retry;
    int crc0, rt0, rf0;
    crc0 = cnt_crc; rt0 = cnt_rd_retry; rf0 = cnt_rd_fail;
    scrub_en = 1'b1;
    send(8'hC0, 4'h1, 4'd5);
    chk("R1", "rq_valid", rq_valid, 1);
    chk("R1", "res_valid", res_valid, 0);
    chk("R1", "rq_op", rq_op, 8'hE0);
    chk("R1", "rq_tag", rq_tag, 5);
    chk("R1", "retry count delta", cnt_rd_retry - rt0, 1);
    chk("R1", "read fail delta", cnt_rd_fail - rf0, 0);
    chk("R8", "crc delta on retry", cnt_crc - crc0, 1);
  endtask

  task automatic t_read_noscrub;
    int hd0, rf0;
    hd0 = cnt_hard; rf0 = cnt_rd_fail;
    scrub_en = 1'b0;
    send(8'hC0, 4'h2, 4'd6);
    chk("R2", "res_valid", res_valid, 1);
    chk("R2", "rq_valid", rq_valid, 0);
    chk("R2", "res_code", res_code, 2);
    chk("R2", "res_tag", res_tag, 6);
    chk("R2", "read fail delta", cnt_rd_fail - rf0, 1);
    chk("R8", "hard delta", cnt_hard - hd0, 1);
  endtask

  task automatic t_read_other;
    int rf0, sf0;
    scrub_en = 1'b1;
    rf0 = cnt_rd_fail;
    send(8'hC0, 4'h8, 4'd7);
    chk("R3", "fault-only code", res_code, 2);
    chk("R3", "fault-only valid", res_valid, 1);
    chk("R3", "fault-only fail delta", cnt_rd_fail - rf0, 1);
    rf0 = cnt_rd_fail; sf0 = cnt_soft;
    send(8'hC0, 4'h4, 4'd8);
    chk("R3", "soft-only code", res_code, 0);
    chk("R3", "soft-only valid", res_valid, 1);
    chk("R3", "soft-only fail delta", cnt_rd_fail - rf0, 0);
    chk("R8", "soft delta", cnt_soft - sf0, 1);
  endtask

  task automatic t_recon;
    int rf0, rt0;
    scrub_en = 1'b1;
    rf0 = cnt_rd_fail; rt0 = cnt_rd_retry;
    send(8'hE0, 4'h3, 4'd2);
    chk("R4", "recon media code", res_code, 2);
    chk("R4", "recon no retry", rq_valid, 0);
    chk("R4", "recon fail delta", cnt_rd_fail - rf0, 1);
    chk("R4", "recon retry delta", cnt_rd_retry - rt0, 0);
    rf0 = cnt_rd_fail;
    send(8'hE0, 4'hC, 4'd3);
    chk("R4", "recon soft/fault code", res_code, 0);
    chk("R4", "recon soft/fault fail delta", cnt_rd_fail - rf0, 0);
  endtask

  task automatic t_wr_dc;
    int wf0, df0;
    wf0 = cnt_wr_fail; df0 = cnt_dc_fail;
    send(8'h80, 4'h4, 4'd10);
    chk("R5", "write code", res_code, 2);
    chk("R5", "write fail delta", cnt_wr_fail - wf0, 1);
    send(8'h70, 4'h8, 4'd11);
    chk("R5", "discard code", res_code, 2);
    chk("R5", "discard fail delta", cnt_dc_fail - df0, 1);
    chk("R5", "write fail untouched by discard", cnt_wr_fail - wf0, 1);
  endtask

  task automatic t_unknown;
    int crc0, wf0, df0, rf0;
    crc0 = cnt_crc; wf0 = cnt_wr_fail; df0 = cnt_dc_fail; rf0 = cnt_rd_fail;
    send(8'h55, 4'h1, 4'd12);
    chk("R6", "unknown code", res_code, 1);
    chk("R6", "fail counters delta", (cnt_wr_fail - wf0) + (cnt_dc_fail - df0)
        + (cnt_rd_fail - rf0), 0);
    chk("R8", "crc delta on unknown", cnt_crc - crc0, 1);
  endtask

  task automatic t_zero;
    int sum0;
    sum0 = cnt_crc + cnt_hard + cnt_soft + cnt_rd_retry + cnt_rd_fail + cnt_wr_fail + cnt_dc_fail;
    send(8'hC0, 4'h0, 4'd13);
    chk("R7", "read zero code", res_code, 0);
    send(8'h55, 4'h0, 4'd14);
    chk("R7", "unknown zero code", res_code, 0);
    chk("R7", "counters unchanged", cnt_crc + cnt_hard + cnt_soft + cnt_rd_retry
        + cnt_rd_fail + cnt_wr_fail + cnt_dc_fail, sum0);
  endtask

  task automatic t_backpressure;
    scrub_en = 1'b1;
    rq_ready = 1'b0;
    send(8'hC0, 4'h1, 4'd9);
    chk("R10", "retry held", rq_valid, 1);
    in_valid = 1'b1; in_op = 8'h80; in_status = 4'h0; in_tag = 4'd3;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R10", "in_ready while stalled", in_ready, 0);
      chk("R10", "retry tag stable", rq_tag, 9);
      chk("R10", "no result while stalled", res_valid, 0);
      @(negedge clk);
    end
    rq_ready = 1'b1;
    #1;
    chk("R11", "in_ready when draining", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11", "retry drained", rq_valid, 0);
    chk("R11", "new record taken", res_valid, 1);
    chk("R11", "new record tag", res_tag, 3);
    chk("R11", "new record code", res_code, 0);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 300; i++) send(8'h80, 4'h1, 4'd1);
    chk("R9", "crc saturated", cnt_crc, 255);
    chk("R9", "write fail saturated", cnt_wr_fail, 255);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read_retry();
    t_read_noscrub();
    t_read_other();
    t_recon();
    t_wr_dc();
    t_unknown();
    t_zero();
    t_backpressure();
    t_saturate();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule